// File: doc/BRIEF.md
# Hashed Page Table Group Matcher

This block looks through one group of eight page table entries for the entry that translates a virtual page. Each entry has two 64-bit words. The V word holds the abbreviated virtual page number (AVPN) and the flag bits. The R word holds the real page number and the protection bits.

The group is held in an internal store, which can be filled in two ways:

- all eight entries in one cycle from a flat parallel bus, or
- one slot at a time through a slot-write port.

A lookup begins with a one-cycle `start` strobe that carries a compare key shaped like a V word. One clock edge later, registered results appear together with a one-cycle `done` pulse:

- whether an entry hit, and the lowest slot that hit;
- the R word of that slot, and whether the match came through the secondary hash;
- whether more than one slot hit;
- the lowest empty slot, for inserting a new entry, and a flag that is raised when all eight slots are valid.

Fetching the group from memory, writing back the reference and change bits, and choosing an entry to evict are left to the caller.

The control is a two-state machine:

- **S_IDLE**: waiting, `done` low.
- **S_REPORT**: the cycle after a lookup, `done` high.

The transitions are:

- S_IDLE → S_REPORT on `start`.
- S_REPORT → S_REPORT on a back-to-back `start`.
- S_REPORT → S_IDLE when `start` is low.

Top module: `ptg_matcher`

## Requirements
- R1: After reset the store is cleared, so every slot's valid bit is 0. While reset is held, `done`, `hit`, `multi_hit`, `group_full` and `free_found` are 0. The first lookup after reset reports no hit, `free_found`=1, `free_slot`=0 and `group_full`=0.
- R2: Slot i hits under all three of these conditions:
  - its V bit 0 (valid) is 1;
  - V bits 63:7 equal key bits 63:7;
  - V bit 1 (secondary-hash flag) equals key bit 1.

  Key bits 0 and 2..6 are ignored. So are entry bits 2 (large page), 3 (lock) and 4 (bolted): locked or bolted entries still match.
- R3: When several slots hit, `hit_slot` is the lowest of them and `multi_hit` is 1. With exactly one hit, `multi_hit` is 0.
- R4: On a hit, `hit_r` is the R word of the reported slot. `hit_secondary` is that slot's V bit 1, which equals key bit 1.
- R5: `free_slot` is the lowest index whose V bit 0 is 0, and `free_found` is 1 when such a slot exists. When all eight slots are valid, `group_full`=1, `free_found`=0 and `free_slot`=0.
- R6: The results of a `start` sampled at edge k are visible after edge k, and `done` is 1 for exactly the following cycle unless `start` is repeated. The results hold until the next `start`.
- R7: When `load_all` is high, slot i is loaded with V=`all_v[64*i+63:64*i]` and R=`all_r[64*i+63:64*i]`. If `load_one` is high at the same edge, `load_all` wins and the slot write is dropped.
- R8: When `load_one` is high without `load_all`, slot `one_slot` is loaded with `one_v`/`one_r`, and the other slots keep their contents.
- R9: A lookup compares against the store as it was before the edge at which `start` is sampled. A write at that same edge is seen only by later lookups.
- R10: With no hit, `hit_slot`=0, `hit_r`=0, `hit_secondary`=0 and `multi_hit`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_all | input | 1 | Load the whole group from the parallel buses |
| all_v | input | 512 | V words, slot i in bits 64*i+63:64*i |
| all_r | input | 512 | R words, slot i in bits 64*i+63:64*i |
| load_one | input | 1 | Write a single slot |
| one_slot | input | 3 | Slot index for the single write |
| one_v | input | 64 | V word for the single write |
| one_r | input | 64 | R word for the single write |
| start | input | 1 | Lookup strobe |
| key_v | input | 64 | Compare key in V-word layout |
| done | output | 1 | One-cycle pulse: results valid |
| hit | output | 1 | A slot matched |
| hit_slot | output | 3 | Lowest matching slot |
| hit_r | output | 64 | R word of the matching slot |
| hit_secondary | output | 1 | Match came through the secondary hash |
| multi_hit | output | 1 | More than one slot matched |
| free_found | output | 1 | At least one slot is empty |
| free_slot | output | 3 | Lowest empty slot |
| group_full | output | 1 | All slots valid |

## Verification
Every result of a lookup is registered at the edge that samples `start`, so the bench drives `start` on a falling edge. It reads `done` and all result ports at the very next falling edge, one full cycle later. It then confirms at the falling edge after that both that `done` has dropped and that the results are still held.

Loads take effect at one edge and are first observable through a lookup whose `start` is sampled at a later edge. The same-edge case of R9 is checked by sampling `start` and a slot write at the same edge, then comparing the two lookups that follow.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
    localparam int unsigned PTG_SLOTS  = 8;
    localparam int unsigned PTG_WORD_W = 64;
    localparam int unsigned PTG_FLAG_W = 7;
    localparam int unsigned PTG_VALID  = 0;
    localparam int unsigned PTG_SECOND = 1;

    typedef enum logic {
        S_IDLE   = 1'b0,
        S_REPORT = 1'b1
    } ptg_state_e;
endpackage

// File: rtl/ptg_store.sv
module ptg_store #(
    parameter int unsigned SLOTS  = 8,
    parameter int unsigned WORD_W = 64,
    localparam int unsigned IDX_W = $clog2(SLOTS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load_all,
    input  logic [SLOTS*WORD_W-1:0]       all_v,
    input  logic [SLOTS*WORD_W-1:0]       all_r,
    input  logic                          load_one,
    input  logic [IDX_W-1:0]              one_slot,
    input  logic [WORD_W-1:0]             one_v,
    input  logic [WORD_W-1:0]             one_r,
    output logic [SLOTS-1:0][WORD_W-1:0]  v_q,
    output logic [SLOTS-1:0][WORD_W-1:0]  r_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0;
            r_q <= '0;
        end else if (load_all) begin
            for (int i = 0; i < int'(SLOTS); i++) begin
                v_q[i] <= all_v[i*WORD_W +: WORD_W];
                r_q[i] <= all_r[i*WORD_W +: WORD_W];
            end
        end else if (load_one) begin
            v_q[one_slot] <= one_v;
            r_q[one_slot] <= one_r;
        end
    end
endmodule

// File: rtl/ptg_slot_cmp.sv
module ptg_slot_cmp #(
    parameter int unsigned WORD_W = 64,
    parameter int unsigned FLAG_W = 7,
    parameter int unsigned VALID  = 0,
    parameter int unsigned SECOND = 1,
    localparam logic [WORD_W-1:0] CMP_MASK =
        ({WORD_W{1'b1}} << FLAG_W) | (WORD_W'(1) << SECOND)
) (
    input  logic [WORD_W-1:0] entry_v,
    input  logic [WORD_W-1:0] key_v,
    output logic              match,
    output logic              valid
);
    logic [WORD_W-1:0] diff;

    always_comb begin
        diff  = entry_v ^ key_v;
        valid = entry_v[VALID];
        match = valid && ((diff & CMP_MASK) == '0);
    end
endmodule

// File: rtl/ptg_lowest.sv
module ptg_lowest #(
    parameter int unsigned N = 8,
    localparam int unsigned IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx,
    output logic             multi
);
    always_comb begin
        any   = 1'b0;
        idx   = '0;
        multi = 1'b0;
        for (int i = 0; i < int'(N); i++) begin
            if (req[i]) begin
                if (any) begin
                    multi = 1'b1;
                end else begin
                    any = 1'b1;
                    idx = IDX_W'(i);
                end
            end
        end
    end
endmodule

// File: rtl/ptg_matcher.sv
module ptg_matcher
    import ptg_pkg::*;
#(
    parameter int unsigned SLOTS  = PTG_SLOTS,
    parameter int unsigned WORD_W = PTG_WORD_W,
    parameter int unsigned FLAG_W = PTG_FLAG_W,
    localparam int unsigned IDX_W = $clog2(SLOTS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_all,
    input  logic [SLOTS*WORD_W-1:0] all_v,
    input  logic [SLOTS*WORD_W-1:0] all_r,
    input  logic                    load_one,
    input  logic [IDX_W-1:0]        one_slot,
    input  logic [WORD_W-1:0]       one_v,
    input  logic [WORD_W-1:0]       one_r,
    input  logic                    start,
    input  logic [WORD_W-1:0]       key_v,
    output logic                    done,
    output logic                    hit,
    output logic [IDX_W-1:0]        hit_slot,
    output logic [WORD_W-1:0]       hit_r,
    output logic                    hit_secondary,
    output logic                    multi_hit,
    output logic                    free_found,
    output logic [IDX_W-1:0]        free_slot,
    output logic                    group_full
);
    logic [SLOTS-1:0][WORD_W-1:0] v_q;
    logic [SLOTS-1:0][WORD_W-1:0] r_q;
    logic [SLOTS-1:0]             slot_match;
    logic [SLOTS-1:0]             slot_valid;

    logic             m_any, m_multi;
    logic [IDX_W-1:0] m_idx;
    logic             f_any, f_multi;
    logic [IDX_W-1:0] f_idx;

    logic [WORD_W-1:0] sel_r;
    logic              sel_sec;

    ptg_state_e state_q, state_d;

    ptg_store #(.SLOTS(SLOTS), .WORD_W(WORD_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_all (load_all),
        .all_v    (all_v),
        .all_r    (all_r),
        .load_one (load_one),
        .one_slot (one_slot),
        .one_v    (one_v),
        .one_r    (one_r),
        .v_q      (v_q),
        .r_q      (r_q)
    );

    for (genvar g = 0; g < int'(SLOTS); g++) begin : g_slot
        ptg_slot_cmp #(
            .WORD_W (WORD_W),
            .FLAG_W (FLAG_W),
            .VALID  (PTG_VALID),
            .SECOND (PTG_SECOND)
        ) u_cmp (
            .entry_v (v_q[g]),
            .key_v   (key_v),
            .match   (slot_match[g]),
            .valid   (slot_valid[g])
        );
    end

    ptg_lowest #(.N(SLOTS)) u_hit_pick (
        .req   (slot_match),
        .any   (m_any),
        .idx   (m_idx),
        .multi (m_multi)
    );

    ptg_lowest #(.N(SLOTS)) u_free_pick (
        .req   (~slot_valid),
        .any   (f_any),
        .idx   (f_idx),
        .multi (f_multi)
    );

    always_comb begin
        sel_r   = '0;
        sel_sec = 1'b0;
        if (m_any) begin
            sel_r   = r_q[m_idx];
            sel_sec = v_q[m_idx][PTG_SECOND];
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   state_d = start ? S_REPORT : S_IDLE;
            S_REPORT: state_d = start ? S_REPORT : S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    assign done = (state_q == S_REPORT);

    // Output registers: captured at the edge that samples start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit           <= 1'b0;
            hit_slot      <= '0;
            hit_r         <= '0;
            hit_secondary <= 1'b0;
            multi_hit     <= 1'b0;
            free_found    <= 1'b0;
            free_slot     <= '0;
            group_full    <= 1'b0;
        end else if (start) begin
            hit           <= m_any;
            hit_slot      <= m_idx;
            hit_r         <= sel_r;
            hit_secondary <= sel_sec;
            multi_hit     <= m_multi;
            free_found    <= f_any;
            free_slot     <= f_idx;
            group_full    <= ~f_any & (f_multi | 1'b1);
        end
    end
endmodule

// File: rtl/ptg_matcher_chk.sv
module ptg_matcher_chk #(
    parameter int unsigned WORD_W = 64,
    parameter int unsigned IDX_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [WORD_W-1:0] key_v,
    input logic              done,
    input logic              hit,
    input logic [IDX_W-1:0]  hit_slot,
    input logic [WORD_W-1:0] hit_r,
    input logic              hit_secondary,
    input logic              multi_hit,
    input logic              free_found,
    input logic [IDX_W-1:0]  free_slot,
    input logic              group_full
);
    a_r6_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    a_r6_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(hit) && $stable(hit_slot) && $stable(hit_r)
                    && $stable(free_slot) && $stable(group_full)));

    a_r3_multi_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        multi_hit |-> hit);

    a_r4_secondary_follows_key: assert property (@(posedge clk) disable iff (!rst_n)
        (done && hit) |-> (hit_secondary == $past(key_v[1])));

    a_r5_full_has_no_free: assert property (@(posedge clk) disable iff (!rst_n)
        group_full |-> (!free_found && free_slot == '0));

    a_r5_free_xor_full: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (free_found != group_full));

    a_r10_nohit_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (hit_slot == '0 && hit_r == '0 && !hit_secondary && !multi_hit));
endmodule

bind ptg_matcher ptg_matcher_chk #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .key_v         (key_v),
    .done          (done),
    .hit           (hit),
    .hit_slot      (hit_slot),
    .hit_r         (hit_r),
    .hit_secondary (hit_secondary),
    .multi_hit     (multi_hit),
    .free_found    (free_found),
    .free_slot     (free_slot),
    .group_full    (group_full)
);

// File: tb/ptg_matcher_tb.sv
module ptg_matcher_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_all = 1'b0;
    logic [511:0] all_v = '0;
    logic [511:0] all_r = '0;
    logic         load_one = 1'b0;
    logic [2:0]   one_slot = '0;
    logic [63:0]  one_v = '0;
    logic [63:0]  one_r = '0;
    logic         start = 1'b0;
    logic [63:0]  key_v = '0;
    logic         done, hit, hit_secondary, multi_hit, free_found, group_full;
    logic [2:0]   hit_slot, free_slot;
    logic [63:0]  hit_r;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    ptg_matcher u_dut (
        .clk(clk), .rst_n(rst_n), .load_all(load_all), .all_v(all_v), .all_r(all_r),
        .load_one(load_one), .one_slot(one_slot), .one_v(one_v), .one_r(one_r),
        .start(start), .key_v(key_v), .done(done), .hit(hit), .hit_slot(hit_slot),
        .hit_r(hit_r), .hit_secondary(hit_secondary), .multi_hit(multi_hit),
        .free_found(free_found), .free_slot(free_slot), .group_full(group_full)
    );

    function automatic logic [63:0] mk_v(input logic [56:0] avpn, input logic [6:0] fl);
        return {avpn, fl};
    endfunction

    function automatic logic [63:0] r_of(input int i);
        return 64'h3000_0000_0000_0000 | (64'(i + 1) << 12) | 64'(i % 4);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic lookup(input logic [63:0] k);
        @(negedge clk);
        start = 1'b1;
        key_v = k;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic write_one(input logic [2:0] s, input logic [63:0] v, input logic [63:0] r);
        @(negedge clk);
        load_one = 1'b1; one_slot = s; one_v = v; one_r = r;
        @(negedge clk);
        load_one = 1'b0;
    endtask

    // key (64) | exp_hit | exp_slot(3) | exp_multi
    localparam int NVEC = 10;
    localparam logic [68:0] VEC [NVEC] = '{
        {57'h100, 7'h00, 1'b1, 3'd0, 1'b0},   // R2 plain primary match
        {57'h100, 7'h7D, 1'b1, 3'd0, 1'b0},   // R2 key bits 0,2..6 ignored
        {57'h100, 7'h02, 1'b0, 3'd0, 1'b0},   // R2 secondary flag differs
        {57'h200, 7'h02, 1'b1, 3'd1, 1'b0},   // R2/R4 secondary match
        {57'h200, 7'h00, 1'b1, 3'd6, 1'b0},   // R2 primary twin in slot 6
        {57'h300, 7'h00, 1'b1, 3'd2, 1'b0},   // R2 locked+bolted still match
        {57'h400, 7'h00, 1'b0, 3'd0, 1'b0},   // R2 invalid slot never hits
        {57'h500, 7'h00, 1'b1, 3'd4, 1'b1},   // R3 two hits, lowest reported
        {57'h600, 7'h00, 1'b0, 3'd0, 1'b0},   // R10 invalid, no hit
        {57'h101, 7'h00, 1'b0, 3'd0, 1'b0}    // R2 AVPN lsb differs
    };

    logic [63:0] gv [8];

    initial begin
        gv[0] = mk_v(57'h100, 7'h01);
        gv[1] = mk_v(57'h200, 7'h03);
        gv[2] = mk_v(57'h300, 7'h19);
        gv[3] = mk_v(57'h400, 7'h00);
        gv[4] = mk_v(57'h500, 7'h05);
        gv[5] = mk_v(57'h500, 7'h01);
        gv[6] = mk_v(57'h200, 7'h01);
        gv[7] = mk_v(57'h600, 7'h00);

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 done in reset", 64'(done), 64'd0);
        chk("R1 hit in reset", 64'(hit), 64'd0);
        chk("R1 full in reset", 64'(group_full), 64'd0);
        rst_n = 1'b1;

        lookup(64'h0);
        chk("R1 first lookup hit", 64'(hit), 64'd0);
        chk("R1 first lookup free_found", 64'(free_found), 64'd1);
        chk("R1 first lookup free_slot", 64'(free_slot), 64'd0);
        chk("R6 done after start", 64'(done), 64'd1);
        @(negedge clk);
        chk("R6 done single pulse", 64'(done), 64'd0);

        // R7 parallel load of the table group
        @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            all_v[i*64 +: 64] = gv[i];
            all_r[i*64 +: 64] = r_of(i);
        end
        load_all = 1'b1;
        @(negedge clk);
        load_all = 1'b0;

        for (int n = 0; n < NVEC; n++) begin
            logic [63:0] k;
            logic        eh, em;
            logic [2:0]  es;
            {k, eh, es, em} = VEC[n];
            lookup(k);
            chk($sformatf("R2 vec%0d hit", n), 64'(hit), 64'(eh));
            chk($sformatf("R3 vec%0d slot", n), 64'(hit_slot), 64'(es));
            chk($sformatf("R3 vec%0d multi", n), 64'(multi_hit), 64'(em));
            chk($sformatf("R4 vec%0d r", n), hit_r, eh ? r_of(int'(es)) : 64'h0);
            chk($sformatf("R4 vec%0d sec", n), 64'(hit_secondary), eh ? 64'(k[1]) : 64'd0);
            chk($sformatf("R5 vec%0d free", n), 64'(free_slot), 64'd3);
            chk($sformatf("R5 vec%0d full", n), 64'(group_full), 64'd0);
        end

        // R6 results hold after done falls
        lookup(mk_v(57'h300, 7'h00));
        @(negedge clk);
        @(negedge clk);
        chk("R6 hold done low", 64'(done), 64'd0);
        chk("R6 hold hit", 64'(hit), 64'd1);
        chk("R6 hold slot", 64'(hit_slot), 64'd2);

        // R9 same-edge write not seen
        @(negedge clk);
        start = 1'b1; key_v = mk_v(57'h600, 7'h00);
        load_one = 1'b1; one_slot = 3'd7; one_v = mk_v(57'h600, 7'h01); one_r = r_of(7);
        @(negedge clk);
        start = 1'b0; load_one = 1'b0;
        chk("R9 same-edge write unseen", 64'(hit), 64'd0);
        lookup(mk_v(57'h600, 7'h00));
        chk("R9 later lookup sees write", 64'(hit), 64'd1);
        chk("R8 slot 7 written", 64'(hit_slot), 64'd7);
        chk("R5 free still slot 3", 64'(free_slot), 64'd3);

        // R8 single write leaves others alone; R5 full group
        write_one(3'd3, mk_v(57'h400, 7'h01), r_of(3));
        lookup(mk_v(57'h400, 7'h00));
        chk("R8 slot 3 hit", 64'(hit_slot), 64'd3);
        chk("R8 slot 3 r", hit_r, r_of(3));
        chk("R5 group full", 64'(group_full), 64'd1);
        chk("R5 no free found", 64'(free_found), 64'd0);
        chk("R5 free slot zero", 64'(free_slot), 64'd0);
        lookup(mk_v(57'h100, 7'h00));
        chk("R8 slot 0 untouched", hit_r, r_of(0));

        // R7 load_all wins over load_one
        @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            all_v[i*64 +: 64] = mk_v(57'(12'h700 + i), 7'h01);
            all_r[i*64 +: 64] = r_of(i);
        end
        load_all = 1'b1;
        load_one = 1'b1; one_slot = 3'd0; one_v = mk_v(57'h7FF, 7'h01); one_r = 64'h1;
        @(negedge clk);
        load_all = 1'b0; load_one = 1'b0;
        lookup(mk_v(57'h7FF, 7'h00));
        chk("R7 dropped slot write", 64'(hit), 64'd0);
        lookup(mk_v(57'h705, 7'h00));
        chk("R7 parallel slot 5", 64'(hit_slot), 64'd5);
        chk("R7 parallel slot 5 r", hit_r, r_of(5));

        // R6 back-to-back starts keep done high
        @(negedge clk);
        start = 1'b1; key_v = mk_v(57'h700, 7'h00);
        @(negedge clk);
        key_v = mk_v(57'h702, 7'h00);
        chk("R6 b2b first done", 64'(done), 64'd1);
        chk("R6 b2b first slot", 64'(hit_slot), 64'd0);
        @(negedge clk);
        start = 1'b0;
        chk("R6 b2b second done", 64'(done), 64'd1);
        chk("R6 b2b second slot", 64'(hit_slot), 64'd2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R6 actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule